// File: doc/BRIEF.md
# Write Leveling Feedback Responder

This block sits on the memory-device side of a DDR-style link and models how the device answers a controller that is aligning its write strobe to the clock. A write to mode register 1 switches the device into or out of leveling mode and sets whether its data outputs are disabled. While leveling, the on-die termination input switches only the strobe termination, and data termination stays off. Each rising strobe edge captures the level of the device clock. That level is sent back on the data bits after a fixed number of clock cycles, and no read strobe goes with it.

A parameter selects the feedback layout. In prime-bit mode, bit 0 alone carries the sampled level and every other bit stays low. In all-bit mode, every bit carries it, and each bit may lag by a small extra amount to model bit-to-bit skew. Two flags report controller mistakes. One is an illegal nominal-termination code chosen for leveling with outputs on. The other is a disallowed command issued during leveling.

Top module: `wrlvl_echo`

## Requirements
- R1: A command with `cmdOp`=2 (mode register write) and `cmdBank`=1 loads the mode: `cmdAddr[7]`=1 enters leveling, `cmdAddr[7]`=0 leaves it, and `cmdAddr[12]`=1 disables the data outputs. Writes to any other bank leave the mode unchanged. The new mode is visible after the clock edge that samples the write.
- R2: `dqOe` is 1 exactly while leveling is active with outputs enabled. While `dqOe` is 0, `dqOut` is all zeros. `dqOe` is 0 after reset.
- R3: While leveling, `rttStrobeEn` equals `odtIn` and `rttDataEn` is 0. Outside leveling, both follow `odtIn`.
- R4: A capture happens only in leveling mode, and only on a clock edge that samples `strobeIn` high after it was sampled low at the previous edge. The capture takes `ckLevel`. A strobe held high, or a strobe pulse outside leveling mode, captures nothing.
- R5: A bit with no skew shows a new captured level from the WLO-th rising clock edge on, counting the capturing edge as the first. Until then it shows the previous level.
- R6: In all-bit mode, bit i lags by a further i mod (SKEW+1) clock cycles.
- R7: In prime-bit mode, bit 0 carries the feedback and bits 1 and above stay 0 throughout.
- R8: In all-bit mode, every bit carries the same captured level once its delay has elapsed.
- R9: `illegalRtt` pulses for one cycle after a bank-1 write with bit 7 = 1, bit 12 = 0 and termination code {addr[9],addr[6],addr[2]} outside {1,2,3}. It stays 0 otherwise, including when bit 12 = 1.
- R10: `protoErr` pulses for one cycle after a command issued while leveling that is neither `cmdOp`=0 (no-op), `cmdOp`=1 (deselect) nor a bank-1 mode register write. It is never raised outside leveling.
- R11: Leaving leveling clears the captured level and its delay line. A later re-entry therefore shows 0 until a new capture arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdOp | input | 3 | Command code: 0 no-op, 1 deselect, 2 mode register write, others are other commands |
| cmdBank | input | 3 | Mode register select for a mode register write |
| cmdAddr | input | ADDR_W | Mode register payload |
| odtIn | input | 1 | On-die termination request |
| strobeIn | input | 1 | Write strobe, sampled at the clock |
| ckLevel | input | 1 | Clock level seen by the strobe sampler |
| dqOut | output | DQ_W | Leveling feedback data |
| dqOe | output | 1 | Data output enable |
| rttStrobeEn | output | 1 | Strobe termination enable |
| rttDataEn | output | 1 | Data termination enable |
| illegalRtt | output | 1 | Illegal termination code pulse |
| protoErr | output | 1 | Disallowed command pulse |

## Verification
The bench builds two copies side by side on shared inputs. The first is prime-bit with WLO=3 and SKEW=0. The second is all-bit with WLO=2, SKEW=2 and eight bits, so its bits settle over three consecutive edges. With both copies, one strobe pulse checks the latency edge and the previous-value window of each layout, and the staggered settling of bits 0, 1 and 2 in the skewed copy. The short latencies also leave room to check a held strobe, a pulse outside the mode, and re-entry after exit within a few cycles.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_DESEL = 3'd1;
  localparam logic [2:0] OP_MRW   = 3'd2;
  localparam logic [2:0] MR1_SEL  = 3'd1;
  localparam int BIT_LVL  = 7;
  localparam int BIT_QOFF = 12;

  typedef struct packed {
    logic lvlOn;    // leveling mode active
    logic drvEn;    // leveling with outputs enabled
    logic capture;  // sample the clock level this cycle
  } lvlStrobes_t;

  function automatic logic rttLegal(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction
endpackage

// File: rtl/wrlvl_ctrl.sv
module wrlvl_ctrl
  import wrlvl_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdOp,
  input  logic [2:0]        cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              odtIn,
  input  logic              strobeIn,
  output lvlStrobes_t       stb,
  output logic              rttStrobeEn,
  output logic              rttDataEn,
  output logic              illegalRtt,
  output logic              protoErr
);
  logic lvlMode, qOff, strobePrev, illegalQ, protoQ;
  logic isMr1, quietCmd;
  logic [2:0] rttCode;

  always_comb begin
    isMr1    = (cmdOp == OP_MRW) && (cmdBank == MR1_SEL);
    quietCmd = (cmdOp == OP_NOP) || (cmdOp == OP_DESEL);
    rttCode  = {cmdAddr[9], cmdAddr[6], cmdAddr[2]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlMode    <= 1'b0;
      qOff       <= 1'b0;
      strobePrev <= 1'b0;
      illegalQ   <= 1'b0;
      protoQ     <= 1'b0;
    end else begin
      if (isMr1) begin
        lvlMode <= cmdAddr[BIT_LVL];
        qOff    <= cmdAddr[BIT_QOFF];
      end
      strobePrev <= strobeIn;
      illegalQ   <= isMr1 && cmdAddr[BIT_LVL] && !cmdAddr[BIT_QOFF] && !rttLegal(rttCode);
      protoQ     <= lvlMode && !quietCmd && !isMr1;
    end
  end

  always_comb begin
    stb.lvlOn   = lvlMode;
    stb.drvEn   = lvlMode && !qOff;
    stb.capture = lvlMode && strobeIn && !strobePrev;
    rttStrobeEn = odtIn;
    rttDataEn   = odtIn && !lvlMode;
    illegalRtt  = illegalQ;
    protoErr    = protoQ;
  end
endmodule

// File: rtl/wrlvl_dpath.sv
module wrlvl_dpath
  import wrlvl_pkg::*;
#(
  parameter int DQ_W   = 8,
  parameter int WLO    = 4,
  parameter int SKEW   = 1,
  parameter bit ALL_DQ = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  lvlStrobes_t     stb,
  input  logic            ckLevel,
  output logic [DQ_W-1:0] dqOut,
  output logic            dqOe
);
  localparam int LINE_D = WLO + (ALL_DQ ? SKEW : 0);

  logic capQ, nextCap;
  logic [LINE_D-1:0] line;

  always_comb begin
    if (!stb.lvlOn)       nextCap = 1'b0;
    else if (stb.capture) nextCap = ckLevel;
    else                  nextCap = capQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ <= 1'b0;
      line <= '0;
    end else begin
      capQ <= nextCap;
      if (!stb.lvlOn) begin
        line <= '0;
      end else begin
        line[0] <= nextCap;
        for (int j = 1; j < LINE_D; j++) line[j] <= line[j-1];
      end
    end
  end

  for (genvar i = 0; i < DQ_W; i++) begin : g_bit
    if (ALL_DQ || i == 0) begin : g_live
      localparam int TAP = WLO - 1 + (ALL_DQ ? (i % (SKEW + 1)) : 0);
      assign dqOut[i] = stb.drvEn & line[TAP];
    end else begin : g_low
      assign dqOut[i] = 1'b0;
    end
  end

  assign dqOe = stb.drvEn;
endmodule

// File: rtl/wrlvl_echo.sv
module wrlvl_echo
  import wrlvl_pkg::*;
#(
  parameter int DQ_W   = 8,
  parameter int ADDR_W = 14,
  parameter int WLO    = 4,
  parameter int SKEW   = 1,
  parameter bit ALL_DQ = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdOp,
  input  logic [2:0]        cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              odtIn,
  input  logic              strobeIn,
  input  logic              ckLevel,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic              rttStrobeEn,
  output logic              rttDataEn,
  output logic              illegalRtt,
  output logic              protoErr
);
  lvlStrobes_t stb;

  wrlvl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .odtIn(odtIn), .strobeIn(strobeIn), .stb(stb), .rttStrobeEn(rttStrobeEn),
    .rttDataEn(rttDataEn), .illegalRtt(illegalRtt), .protoErr(protoErr)
  );

  wrlvl_dpath #(.DQ_W(DQ_W), .WLO(WLO), .SKEW(SKEW), .ALL_DQ(ALL_DQ)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .ckLevel(ckLevel), .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: rtl/wrlvl_echo_chk.sv
module wrlvl_echo_chk #(
  parameter int DQ_W   = 8,
  parameter int ADDR_W = 14,
  parameter int SKEW   = 1,
  parameter bit ALL_DQ = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        cmdOp,
  input logic [2:0]        cmdBank,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              odtIn,
  input logic [DQ_W-1:0]   dqOut,
  input logic              dqOe,
  input logic              rttStrobeEn,
  input logic              rttDataEn,
  input logic              illegalRtt,
  input logic              protoErr
);
  logic mr1Wr;
  assign mr1Wr = (cmdOp == 3'd2) && (cmdBank == 3'd1);

  assert_enter_R1: assert property (@(posedge clk) disable iff (!rstN)
    mr1Wr && cmdAddr[7] && !cmdAddr[12] |=> dqOe);
  assert_leave_R1: assert property (@(posedge clk) disable iff (!rstN)
    mr1Wr && !cmdAddr[7] |=> !dqOe);
  assert_dq_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> dqOut == '0);
  assert_lvl_term_R3: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !rttDataEn && (rttStrobeEn == odtIn));
  assert_odt_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !odtIn |-> !rttStrobeEn && !rttDataEn);
  assert_rtt_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(mr1Wr && cmdAddr[7]) |=> !illegalRtt);
  assert_quiet_cmd_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd0 || cmdOp == 3'd1 || mr1Wr) |=> !protoErr);

  if (!ALL_DQ && DQ_W > 1) begin : g_prime
    assert_prime_low_R7: assert property (@(posedge clk) disable iff (!rstN)
      dqOut[DQ_W-1:1] == '0);
  end
  if (ALL_DQ && SKEW == 0) begin : g_all
    assert_all_same_R8: assert property (@(posedge clk) disable iff (!rstN)
      $countones(dqOut) == 0 || $countones(dqOut) == DQ_W);
  end
endmodule

bind wrlvl_echo wrlvl_echo_chk #(.DQ_W(DQ_W), .ADDR_W(ADDR_W), .SKEW(SKEW), .ALL_DQ(ALL_DQ)) u_chk (
  .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
  .odtIn(odtIn), .dqOut(dqOut), .dqOe(dqOe), .rttStrobeEn(rttStrobeEn),
  .rttDataEn(rttDataEn), .illegalRtt(illegalRtt), .protoErr(protoErr)
);

// File: tb/wrlvl_echo_bench.sv
module wrlvl_echo_bench;
  localparam int DQ_W = 8;
  localparam int AW   = 14;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] cmdOp = 3'd0, cmdBank = 3'd0;
  logic [AW-1:0] cmdAddr = '0;
  logic odtIn = 1'b0, strobeIn = 1'b0, ckLevel = 1'b0;

  logic [DQ_W-1:0] dqP, dqA;
  logic oeP, oeA, rsP, rsA, rdP, rdA, ilP, ilA, peP, peA;

  int nChecks = 0, nFails = 0;
  logic lastV = 1'b0;

  always #10 clk = ~clk;

  wrlvl_echo #(.DQ_W(DQ_W), .ADDR_W(AW), .WLO(3), .SKEW(0), .ALL_DQ(1'b0)) u_wrlvl_echo (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .odtIn(odtIn), .strobeIn(strobeIn), .ckLevel(ckLevel), .dqOut(dqP), .dqOe(oeP),
    .rttStrobeEn(rsP), .rttDataEn(rdP), .illegalRtt(ilP), .protoErr(peP));

  wrlvl_echo #(.DQ_W(DQ_W), .ADDR_W(AW), .WLO(2), .SKEW(2), .ALL_DQ(1'b1)) u_wrlvl_echo_all (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .odtIn(odtIn), .strobeIn(strobeIn), .ckLevel(ckLevel), .dqOut(dqA), .dqOe(oeA),
    .rttStrobeEn(rsA), .rttDataEn(rdA), .illegalRtt(ilA), .protoErr(peA));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mrVal(input logic a7, input logic a12, input logic [2:0] code);
    logic [AW-1:0] v = '0;
    v[7] = a7; v[12] = a12; v[9] = code[2]; v[6] = code[1]; v[2] = code[0];
    return v;
  endfunction

  // issue one command for one cycle, return at the following negedge
  task automatic issue(input logic [2:0] op, input logic [2:0] bank, input logic [AW-1:0] a);
    cmdOp = op; cmdBank = bank; cmdAddr = a;
    @(posedge clk); @(negedge clk);
    cmdOp = 3'd0; cmdBank = 3'd0; cmdAddr = '0;
  endtask

  task automatic testReset;
    chk(oeP == 0 && oeA == 0, "R2 reset oe", {oeP, oeA}, 0);
    chk(dqP == 0 && dqA == 0, "R2 reset dq", {dqP, dqA}, 0);
    chk(ilP == 0 && peP == 0, "R9/R10 reset flags", {ilP, peP}, 0);
    odtIn = 1'b1; #1;
    chk(rsP && rdP, "R3 normal termination", {rsP, rdP}, 2'b11);
    odtIn = 1'b0;
  endtask

  task automatic testPulseOutside;
    ckLevel = 1'b1; strobeIn = 1'b1;
    @(posedge clk); @(negedge clk); strobeIn = 1'b0;
    issue(3'd5, 3'd0, '0);
    chk(peP == 0, "R10 no error outside leveling", peP, 0);
    issue(3'd2, 3'd1, mrVal(1, 0, 3'd1));
    chk(oeP && oeA, "R1 enter leveling", {oeP, oeA}, 2'b11);
    chk(ilP == 0 && ilA == 0, "R9 legal code", {ilP, ilA}, 0);
    repeat (4) @(negedge clk);
    chk(dqP == 0 && dqA == 0, "R4 no capture outside leveling", {dqP, dqA}, 0);
    lastV = 1'b0;
  endtask

  task automatic testTerm;
    odtIn = 1'b1; #1;
    chk(rsP && !rdP && rsA && !rdA, "R3 leveling odt on", {rsP, rdP, rsA, rdA}, 4'b1010);
    odtIn = 1'b0; #1;
    chk(!rsP && !rdP, "R3 leveling odt off", {rsP, rdP}, 0);
  endtask

  task automatic testPulse(input logic v);
    logic [DQ_W-1:0] eP, eA;
    ckLevel = v; strobeIn = 1'b1;
    for (int e = 1; e <= 5; e++) begin
      @(posedge clk); @(negedge clk);
      if (e == 1) begin strobeIn = 1'b0; ckLevel = ~v; end
      eP = '0; eP[0] = (e >= 3) ? v : lastV;
      for (int i = 0; i < DQ_W; i++) eA[i] = (e >= 2 + (i % 3)) ? v : lastV;
      chk(dqP == eP, "R5/R7 prime latency", dqP, eP);
      chk(dqA == eA, "R6/R8 all-bit skew", dqA, eA);
    end
    lastV = v;
  endtask

  task automatic testHeld;
    ckLevel = 1'b0; strobeIn = 1'b1;
    @(posedge clk); @(negedge clk);
    ckLevel = 1'b1;
    repeat (6) @(negedge clk);
    chk(dqP[0] == 1'b0 && dqA == '0, "R4 held strobe no recapture", {dqP, dqA}, 0);
    strobeIn = 1'b0; ckLevel = 1'b0;
    @(negedge clk);
    lastV = 1'b0;
  endtask

  task automatic testProto;
    issue(3'd5, 3'd0, '0);
    chk(peP && peA, "R10 bad command", {peP, peA}, 2'b11);
    @(negedge clk);
    chk(!peP, "R10 pulse ends", peP, 0);
    issue(3'd2, 3'd2, mrVal(0, 0, 3'd0));
    chk(peP, "R10 other bank write", peP, 1);
    chk(oeP, "R1 other bank keeps mode", oeP, 1);
    issue(3'd1, 3'd0, '0);
    chk(!peP, "R10 deselect allowed", peP, 0);
  endtask

  task automatic testIllegal;
    issue(3'd2, 3'd1, mrVal(1, 0, 3'd4));
    chk(ilP && ilA, "R9 illegal code", {ilP, ilA}, 2'b11);
    @(negedge clk);
    chk(!ilP, "R9 pulse ends", ilP, 0);
    issue(3'd2, 3'd1, mrVal(1, 1, 3'd4));
    chk(!ilP, "R9 any code with outputs off", ilP, 0);
    chk(!oeP && dqP == 0 && dqA == 0, "R2 outputs off", {oeP, dqP}, 0);
    odtIn = 1'b1; #1;
    chk(rsP && !rdP, "R3 leveling with outputs off", {rsP, rdP}, 2'b10);
    odtIn = 1'b0;
  endtask

  task automatic testExit;
    issue(3'd2, 3'd1, mrVal(0, 0, 3'd0));
    chk(!oeP && !oeA, "R1 leave leveling", {oeP, oeA}, 0);
    odtIn = 1'b1; #1;
    chk(rsP && rdP, "R3 normal after exit", {rsP, rdP}, 2'b11);
    odtIn = 1'b0;
    issue(3'd2, 3'd1, mrVal(1, 0, 3'd2));
    repeat (3) @(negedge clk);
    chk(dqP == 0 && dqA == 0, "R11 cleared on re-entry", {dqP, dqA}, 0);
    lastV = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPulseOutside();
    testTerm();
    testPulse(1'b1);
    testPulse(1'b0);
    testPulse(1'b1);
    testHeld();
    testPulse(1'b1);
    testProto();
    testIllegal();
    testExit();
    testPulse(1'b1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule